// File: doc/BRIEF.md
# Four-Channel DMA Programming Register Block

This block is the software-facing register store of a four-channel direct memory access controller. A host reaches it through a byte-wide I/O port: a 4-bit register offset, an 8-bit write bus, an 8-bit read bus, and separate write and read strobes. The block keeps, for every channel, a base and a current 16-bit address, a base and a current 16-bit count, and a six-bit mode. It also keeps one command byte, one mask bit and one software request bit per channel, and one terminal-count flag per channel. All of this state is presented on flat output buses for the transfer engine next to it.

Sixteen-bit values pass through the byte port in two accesses to the same offset. A single shared pointer bit decides whether an access hits the low or the high byte. The pointer changes state after every access to an address or count offset, and it returns to the low byte when the clear-pointer offset is written. The transfer engine advances a channel one unit at a time through a step strobe. Each step moves the current address, counts the current count down, and flags the terminal count at the end of a block. A channel in auto-initialise mode then reloads its current registers from the base registers.

Top module: `dma_chan_regs`

## Requirements
- R1: Reset and a write of any value to offset 0xD (master clear) leave the command byte at 0x00, all four mask bits at 1, all software requests and terminal-count flags at 0, and the byte pointer on the low byte.
- R2: Each read or write at offsets 0x0 to 0x7 flips the byte pointer (0 = low byte, 1 = high byte). A write to offset 0xC returns the pointer to the low byte.
- R3: For channel n (0 to 3), offset 2n holds the address and offset 2n+1 holds the count. A write stores the addressed byte into both the base and the current register. A read returns the addressed byte of the current register.
- R4: At offset 0xA, write bits 1:0 select a channel and bit 2 sets (1) or clears (0) its mask. A write to 0xE clears all masks. A write to 0xF loads data bits 3:0 as the masks of channels 3 to 0.
- R5: At offset 0xB, write bits 1:0 select a channel and bits 7:2 become its mode: bits 7:6 kind (11 = cascade), bit 5 address decrement, bit 4 auto-initialise, and bits 3:2 direction. The mode output carries the bits 7:2 of the written byte.
- R6: A step on a non-cascade channel whose count is not zero lowers the count by one. It moves the address up by one when mode bit 5 is 0 and down by one when it is 1.
- R7: A step on a channel whose count is zero sets that channel's terminal-count flag and clears its software request. With auto-initialise on, the current address and count reload from the base registers. Otherwise the count wraps to 0xFFFF and the address moves as in R6.
- R8: A step on a channel in cascade mode leaves its current address and count unchanged.
- R9: At offset 0x9, write bits 1:0 select a channel and bit 2 sets or clears its software request. A read at offset 0x8 returns the software requests in bits 7:4 and the terminal-count flags in bits 3:0, then clears the flags. A flag raised in the same cycle as that read stays set.
- R10: A step on a channel whose address or count offset is written in the same cycle is discarded. Only the written byte changes.
- R11: A write to offset 0x8 stores the command byte. A read at offset 0xD returns 0x00. Master clear leaves addresses, counts and modes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_off | input | 4 | Register offset |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_rdata | output | 8 | Read data, valid while io_rd is high, 0 otherwise |
| xfer_step | input | 1 | Transfer engine advances one unit |
| xfer_ch | input | 2 | Channel advanced by xfer_step |
| cfg_cmd | output | 8 | Command byte |
| cfg_mask | output | 4 | Mask bit per channel |
| cfg_sreq | output | 4 | Software request per channel |
| cfg_tc | output | 4 | Terminal-count flag per channel |
| cfg_cascade | output | 4 | Channel is in cascade mode |
| cfg_mode | output | 24 | Six mode bits per channel, channel 0 in the lowest bits |
| cfg_addr | output | 64 | Current address per channel, 16 bits each |
| cfg_count | output | 64 | Current count per channel, 16 bits each |

## Verification
The host side and the transfer engine can touch the same channel in one cycle. The bench provokes this by writing the low count byte of channel 1 in the same cycle as a step on channel 1. It then judges that the written byte landed while the address stayed put and the count took no decrement. The bench also holds a status read in the same cycle as a step that ends a block. It expects that read to return the flags as they stood before the step, and it expects the new terminal-count flag to remain set afterwards.

// File: rtl/dmarf_pkg.sv
package dmarf_pkg;

    localparam int CH_NUM  = 4;
    localparam int CH_W    = $clog2(CH_NUM);
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 2 * BYTE_W;
    localparam int MODE_W  = BYTE_W - CH_W;
    localparam int OFF_W   = 4;

    // control offsets (the upper half of the offset space)
    typedef enum logic [OFF_W-1:0] {
        OFF_CMD        = 4'h8,
        OFF_REQ        = 4'h9,
        OFF_SMASK      = 4'hA,
        OFF_MODE       = 4'hB,
        OFF_CLRPTR     = 4'hC,
        OFF_MCLR       = 4'hD,
        OFF_UNMASK_ALL = 4'hE,
        OFF_MASK_ALL   = 4'hF
    } ctl_off_e;

    localparam logic [1:0] KIND_CASCADE = 2'b11;

    typedef struct packed {
        logic [1:0] kind;       // 11 = cascade
        logic       addr_down;  // 1 = decrement address
        logic       auto_init;  // reload at terminal count
        logic [1:0] dir;        // transfer direction
    } chan_mode_t;

    typedef struct packed {
        logic            val_wr;      // write to an address/count offset
        logic            val_rd;      // read of an address/count offset
        logic            is_cnt;      // count (1) or address (0)
        logic [CH_W-1:0] ch;          // channel of that offset
        logic            cmd_wr;
        logic            stat_rd;
        logic            req_wr;
        logic            smask_wr;
        logic            mode_wr;
        logic            clrptr_wr;
        logic            mclr_wr;
        logic            temp_rd;
        logic            unmask_all_wr;
        logic            mask_all_wr;
    } io_dec_t;

    function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] v,
                                                    input logic hi);
        return hi ? v[WORD_W-1:BYTE_W] : v[BYTE_W-1:0];
    endfunction

    function automatic logic [WORD_W-1:0] put_byte(input logic [WORD_W-1:0] v,
                                                   input logic hi,
                                                   input logic [BYTE_W-1:0] b);
        return hi ? {b, v[BYTE_W-1:0]} : {v[WORD_W-1:BYTE_W], b};
    endfunction

endpackage

// File: rtl/dmarf_decode.sv
module dmarf_decode
    import dmarf_pkg::*;
(
    input  logic [OFF_W-1:0] io_off,
    input  logic             io_wr,
    input  logic             io_rd,
    output io_dec_t          dec
);

    always_comb begin
        dec = '0;
        if (!io_off[OFF_W-1]) begin
            dec.val_wr = io_wr;
            dec.val_rd = io_rd;
            dec.is_cnt = io_off[0];
            dec.ch     = io_off[CH_W:1];
        end else begin
            case (io_off)
                OFF_CMD: begin
                    dec.cmd_wr  = io_wr;
                    dec.stat_rd = io_rd;
                end
                OFF_REQ:        dec.req_wr        = io_wr;
                OFF_SMASK:      dec.smask_wr      = io_wr;
                OFF_MODE:       dec.mode_wr       = io_wr;
                OFF_CLRPTR:     dec.clrptr_wr     = io_wr;
                OFF_MCLR: begin
                    dec.mclr_wr = io_wr;
                    dec.temp_rd = io_rd;
                end
                OFF_UNMASK_ALL: dec.unmask_all_wr = io_wr;
                OFF_MASK_ALL:   dec.mask_all_wr   = io_wr;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dmarf_chan.sv
module dmarf_chan
    import dmarf_pkg::*;
#(
    parameter logic [CH_W-1:0] IDX = '0
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              val_wr,
    input  logic              is_cnt,
    input  logic [CH_W-1:0]   acc_ch,
    input  logic              mode_wr,
    input  logic              ptr_hi,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              step,
    input  logic [CH_W-1:0]   step_ch,
    output logic [WORD_W-1:0] cur_addr,
    output logic [WORD_W-1:0] cur_cnt,
    output chan_mode_t        mode,
    output logic              tc_hit
);

    logic [WORD_W-1:0] base_addr, base_cnt;
    logic              prog_me, mode_me, step_req, step_me, at_end;
    logic [WORD_W-1:0] addr_mv;

    assign prog_me  = val_wr && (acc_ch == IDX);
    assign mode_me  = mode_wr && (wdata[CH_W-1:0] == IDX);
    assign step_req = step && (step_ch == IDX);
    // programming the channel in the same cycle wins over the step
    assign step_me  = step_req && (mode.kind != KIND_CASCADE) && !prog_me;
    assign at_end   = (cur_cnt == '0);
    assign tc_hit   = step_me && at_end;
    assign addr_mv  = mode.addr_down ? cur_addr - WORD_W'(1) : cur_addr + WORD_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr <= '0;
            base_cnt  <= '0;
            cur_addr  <= '0;
            cur_cnt   <= '0;
            mode      <= '0;
        end else begin
            if (prog_me) begin
                if (is_cnt) begin
                    base_cnt <= put_byte(base_cnt, ptr_hi, wdata);
                    cur_cnt  <= put_byte(cur_cnt,  ptr_hi, wdata);
                end else begin
                    base_addr <= put_byte(base_addr, ptr_hi, wdata);
                    cur_addr  <= put_byte(cur_addr,  ptr_hi, wdata);
                end
            end else if (step_me) begin
                if (at_end && mode.auto_init) begin
                    cur_addr <= base_addr;
                    cur_cnt  <= base_cnt;
                end else begin
                    cur_addr <= addr_mv;
                    cur_cnt  <= cur_cnt - WORD_W'(1);
                end
            end
            if (mode_me)
                mode <= chan_mode_t'(wdata[BYTE_W-1:CH_W]);
        end
    end

    // R3: a programmed byte lands in the current register
    p_load_byte_r3: assert property (@(posedge clk) disable iff (rst)
        prog_me && !is_cnt |=> pick_byte(cur_addr, $past(ptr_hi)) == $past(wdata));

    // R6: an ordinary step counts down by one
    p_step_cnt_r6: assert property (@(posedge clk) disable iff (rst)
        step_me && !at_end |=> cur_cnt == $past(cur_cnt) - WORD_W'(1));

    // R7: auto-initialise reloads from the base registers
    p_reload_r7: assert property (@(posedge clk) disable iff (rst)
        step_me && at_end && mode.auto_init |=> cur_addr == base_addr && cur_cnt == base_cnt);

    // R8: cascade channels ignore steps
    p_cascade_hold_r8: assert property (@(posedge clk) disable iff (rst)
        step_req && mode.kind == KIND_CASCADE && !prog_me |=> $stable(cur_addr) && $stable(cur_cnt));

    // R10: an address write in a step cycle leaves the count alone
    p_collide_r10: assert property (@(posedge clk) disable iff (rst)
        step_req && prog_me && !is_cnt |=> $stable(cur_cnt));

endmodule

// File: rtl/dmarf_ctrl.sv
module dmarf_ctrl
    import dmarf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              val_wr,
    input  logic              val_rd,
    input  logic              cmd_wr,
    input  logic              stat_rd,
    input  logic              req_wr,
    input  logic              smask_wr,
    input  logic              clrptr_wr,
    input  logic              mclr_wr,
    input  logic              unmask_all_wr,
    input  logic              mask_all_wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CH_NUM-1:0] tc_hit,
    output logic              ptr_hi,
    output logic [BYTE_W-1:0] cmd_q,
    output logic [CH_NUM-1:0] mask_q,
    output logic [CH_NUM-1:0] sreq_q,
    output logic [CH_NUM-1:0] tc_q
);

    logic              ptr_nx;
    logic [BYTE_W-1:0] cmd_nx;
    logic [CH_NUM-1:0] mask_nx, sreq_nx, tc_nx;
    logic [CH_W-1:0]   wsel;

    assign wsel = wdata[CH_W-1:0];

    always_comb begin
        ptr_nx  = ptr_hi;
        cmd_nx  = cmd_q;
        mask_nx = mask_q;
        sreq_nx = sreq_q;
        tc_nx   = tc_q;
        if (clrptr_wr)
            ptr_nx = 1'b0;
        else if (val_wr || val_rd)
            ptr_nx = !ptr_hi;
        if (cmd_wr)
            cmd_nx = wdata;
        if (smask_wr)
            mask_nx[wsel] = wdata[CH_W];
        else if (unmask_all_wr)
            mask_nx = '0;
        else if (mask_all_wr)
            mask_nx = wdata[CH_NUM-1:0];
        if (req_wr)
            sreq_nx[wsel] = wdata[CH_W];
        sreq_nx = sreq_nx & ~tc_hit;
        if (stat_rd)
            tc_nx = '0;
        tc_nx = tc_nx | tc_hit;
    end

    always_ff @(posedge clk) begin
        if (rst || mclr_wr) begin
            ptr_hi <= 1'b0;
            cmd_q  <= '0;
            mask_q <= '1;
            sreq_q <= '0;
            tc_q   <= '0;
        end else begin
            ptr_hi <= ptr_nx;
            cmd_q  <= cmd_nx;
            mask_q <= mask_nx;
            sreq_q <= sreq_nx;
            tc_q   <= tc_nx;
        end
    end

    // R1: master clear restores the idle control state
    p_mclr_state_r1: assert property (@(posedge clk) disable iff (rst)
        mclr_wr |=> mask_q == '1 && cmd_q == '0 && tc_q == '0 && sreq_q == '0 && !ptr_hi);

    // R2: every data-port access flips the pointer
    p_ptr_flip_r2: assert property (@(posedge clk) disable iff (rst)
        (val_wr || val_rd) |=> ptr_hi != $past(ptr_hi));

    // R2: clear-pointer selects the low byte
    p_ptr_clear_r2: assert property (@(posedge clk) disable iff (rst)
        clrptr_wr |=> !ptr_hi);

    // R4: clear-all leaves no channel masked
    p_unmask_all_r4: assert property (@(posedge clk) disable iff (rst)
        unmask_all_wr |=> mask_q == '0);

    // R9: a flag raised together with a status read survives it
    p_tc_keep_r9: assert property (@(posedge clk) disable iff (rst)
        (|tc_hit) && !mclr_wr |=> (tc_q & $past(tc_hit)) == $past(tc_hit));

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dmarf_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [OFF_W-1:0]           io_off,
    input  logic [BYTE_W-1:0]          io_wdata,
    input  logic                       io_wr,
    input  logic                       io_rd,
    output logic [BYTE_W-1:0]          io_rdata,
    input  logic                       xfer_step,
    input  logic [CH_W-1:0]            xfer_ch,
    output logic [BYTE_W-1:0]          cfg_cmd,
    output logic [CH_NUM-1:0]          cfg_mask,
    output logic [CH_NUM-1:0]          cfg_sreq,
    output logic [CH_NUM-1:0]          cfg_tc,
    output logic [CH_NUM-1:0]          cfg_cascade,
    output logic [CH_NUM*MODE_W-1:0]   cfg_mode,
    output logic [CH_NUM*WORD_W-1:0]   cfg_addr,
    output logic [CH_NUM*WORD_W-1:0]   cfg_count
);

    io_dec_t           dec;
    logic              ptr_hi;
    logic [CH_NUM-1:0] tc_hit;
    logic [WORD_W-1:0] cur_addr [CH_NUM];
    logic [WORD_W-1:0] cur_cnt  [CH_NUM];
    chan_mode_t        mode     [CH_NUM];

    dmarf_decode u_dec (
        .io_off (io_off),
        .io_wr  (io_wr),
        .io_rd  (io_rd),
        .dec    (dec)
    );

    dmarf_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .val_wr        (dec.val_wr),
        .val_rd        (dec.val_rd),
        .cmd_wr        (dec.cmd_wr),
        .stat_rd       (dec.stat_rd),
        .req_wr        (dec.req_wr),
        .smask_wr      (dec.smask_wr),
        .clrptr_wr     (dec.clrptr_wr),
        .mclr_wr       (dec.mclr_wr),
        .unmask_all_wr (dec.unmask_all_wr),
        .mask_all_wr   (dec.mask_all_wr),
        .wdata         (io_wdata),
        .tc_hit        (tc_hit),
        .ptr_hi        (ptr_hi),
        .cmd_q         (cfg_cmd),
        .mask_q        (cfg_mask),
        .sreq_q        (cfg_sreq),
        .tc_q          (cfg_tc)
    );

    for (genvar i = 0; i < CH_NUM; i++) begin : g_ch
        dmarf_chan #(.IDX(CH_W'(i))) u_chan (
            .clk      (clk),
            .rst      (rst),
            .val_wr   (dec.val_wr),
            .is_cnt   (dec.is_cnt),
            .acc_ch   (dec.ch),
            .mode_wr  (dec.mode_wr),
            .ptr_hi   (ptr_hi),
            .wdata    (io_wdata),
            .step     (xfer_step),
            .step_ch  (xfer_ch),
            .cur_addr (cur_addr[i]),
            .cur_cnt  (cur_cnt[i]),
            .mode     (mode[i]),
            .tc_hit   (tc_hit[i])
        );
        assign cfg_addr [i*WORD_W +: WORD_W] = cur_addr[i];
        assign cfg_count[i*WORD_W +: WORD_W] = cur_cnt[i];
        assign cfg_mode [i*MODE_W +: MODE_W] = mode[i];
        assign cfg_cascade[i] = (mode[i].kind == KIND_CASCADE);
    end

    always_comb begin
        io_rdata = '0;
        if (dec.val_rd)
            io_rdata = pick_byte(dec.is_cnt ? cur_cnt[dec.ch] : cur_addr[dec.ch], ptr_hi);
        else if (dec.stat_rd)
            io_rdata = {cfg_sreq, cfg_tc};
        else if (dec.temp_rd)
            io_rdata = '0;
    end

endmodule

// File: tb/tb_dma_chan_regs.sv
`timescale 1ns/100ps
module tb_dma_chan_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  io_off = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_rdata;
    logic        xfer_step = 1'b0;
    logic [1:0]  xfer_ch = '0;
    logic [7:0]  cfg_cmd;
    logic [3:0]  cfg_mask, cfg_sreq, cfg_tc, cfg_cascade;
    logic [23:0] cfg_mode;
    logic [63:0] cfg_addr, cfg_count;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    dma_chan_regs dut (
        .clk(clk), .rst(rst), .io_off(io_off), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
        .xfer_step(xfer_step), .xfer_ch(xfer_ch),
        .cfg_cmd(cfg_cmd), .cfg_mask(cfg_mask), .cfg_sreq(cfg_sreq),
        .cfg_tc(cfg_tc), .cfg_cascade(cfg_cascade), .cfg_mode(cfg_mode),
        .cfg_addr(cfg_addr), .cfg_count(cfg_count)
    );

    function automatic logic [15:0] addr_of(input int ch);
        return cfg_addr[ch*16 +: 16];
    endfunction
    function automatic logic [15:0] cnt_of(input int ch);
        return cfg_count[ch*16 +: 16];
    endfunction
    function automatic logic [5:0] mode_of(input int ch);
        return cfg_mode[ch*6 +: 6];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one bus cycle; a read pushes its expected byte into the scoreboard
    task automatic cyc(input logic w, input logic r, input logic [3:0] off,
                       input logic [7:0] d, input logic st, input logic [1:0] sc,
                       input logic [7:0] exp, input string tag);
        if (r) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
        io_wr = w; io_rd = r; io_off = off; io_wdata = d;
        xfer_step = st; xfer_ch = sc;
        @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0; xfer_step = 1'b0;
    endtask

    task automatic wr(input logic [3:0] off, input logic [7:0] d);
        cyc(1'b1, 1'b0, off, d, 1'b0, 2'd0, 8'h00, "");
    endtask
    task automatic rd(input logic [3:0] off, input logic [7:0] exp, input string tag);
        cyc(1'b0, 1'b1, off, 8'h00, 1'b0, 2'd0, exp, tag);
    endtask
    task automatic step(input logic [1:0] ch);
        cyc(1'b0, 1'b0, 4'h0, 8'h00, 1'b1, ch, 8'h00, "");
    endtask

    // monitor: compares read data against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (io_rd) begin
                n_cmp++;
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL unexpected read: actual %h expected none", io_rdata);
                end else begin
                    automatic logic [7:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    if (io_rdata !== e) begin
                        n_bad++;
                        $display("FAIL %s: actual %h expected %h", t, io_rdata, e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 mask", cfg_mask, 4'hF);
        chk("R1 cmd", cfg_cmd, 8'h00);
        chk("R1 tc", cfg_tc, 4'h0);
        chk("R1 sreq", cfg_sreq, 4'h0);
        rd(4'h8, 8'h00, "R1 status after reset");

        // R3 program channel 0, read back
        wr(4'h0, 8'h34); wr(4'h0, 8'h12);
        wr(4'h1, 8'h03); wr(4'h1, 8'h00);
        chk("R3 addr0", addr_of(0), 16'h1234);
        chk("R3 cnt0", cnt_of(0), 16'h0003);
        rd(4'h0, 8'h34, "R3 addr0 low");
        rd(4'h0, 8'h12, "R3 addr0 high");

        // R2 pointer clear and read toggling
        wr(4'h2, 8'hAA);
        wr(4'hC, 8'h5A);
        wr(4'h2, 8'h55); wr(4'h2, 8'h66);
        chk("R2 addr1 after clear", addr_of(1), 16'h6655);
        wr(4'h3, 8'h10);
        rd(4'h2, 8'h66, "R2 high byte after count write");
        rd(4'h3, 8'h10, "R2 low byte after read toggle");
        wr(4'hC, 8'h00);

        // R5 mode
        wr(4'hB, 8'h48);
        chk("R5 mode0", mode_of(0), 6'h12);
        chk("R5 cascade none", cfg_cascade, 4'h0);

        // R9 software request
        wr(4'h9, 8'h04);
        chk("R9 sreq set", cfg_sreq, 4'h1);

        // R6 steps
        step(2'd0);
        chk("R6 addr0 inc", addr_of(0), 16'h1235);
        chk("R6 cnt0 dec", cnt_of(0), 16'h0002);
        step(2'd0); step(2'd0);
        chk("R6 cnt0 zero", cnt_of(0), 16'h0000);

        // R7 terminal count without auto-initialise
        step(2'd0);
        chk("R7 addr0", addr_of(0), 16'h1238);
        chk("R7 cnt0 wrap", cnt_of(0), 16'hFFFF);
        chk("R7 tc0", cfg_tc, 4'h1);
        chk("R7 sreq cleared", cfg_sreq, 4'h0);
        rd(4'h8, 8'h01, "R9 status with tc0");
        chk("R9 tc cleared by read", cfg_tc, 4'h0);

        // R7 auto-initialise with decrement on channel 2
        wr(4'hC, 8'h00);
        wr(4'h4, 8'h00); wr(4'h4, 8'h80);
        wr(4'h5, 8'h01); wr(4'h5, 8'h00);
        wr(4'hB, 8'h76);
        chk("R5 mode2", mode_of(2), 6'h1D);
        step(2'd2);
        chk("R6 addr2 dec", addr_of(2), 16'h7FFF);
        step(2'd2);
        chk("R7 addr2 reload", addr_of(2), 16'h8000);
        chk("R7 cnt2 reload", cnt_of(2), 16'h0001);
        chk("R7 tc2", cfg_tc, 4'h4);

        // R8 cascade
        wr(4'hB, 8'hC3);
        wr(4'h6, 8'h10); wr(4'h6, 8'h00);
        wr(4'h7, 8'h05); wr(4'h7, 8'h00);
        chk("R8 cascade flag", cfg_cascade, 4'h8);
        step(2'd3);
        chk("R8 addr3 held", addr_of(3), 16'h0010);
        chk("R8 cnt3 held", cnt_of(3), 16'h0005);
        chk("R8 tc unchanged", cfg_tc, 4'h4);

        // R4 masks
        wr(4'hA, 8'h00);
        chk("R4 unmask ch0", cfg_mask, 4'hE);
        wr(4'hA, 8'h02);
        chk("R4 unmask ch2", cfg_mask, 4'hA);
        wr(4'hA, 8'h06);
        chk("R4 mask ch2", cfg_mask, 4'hE);
        wr(4'hE, 8'hFF);
        chk("R4 clear all", cfg_mask, 4'h0);
        wr(4'hA, 8'h05);
        chk("R4 mask ch1", cfg_mask, 4'h2);
        wr(4'hF, 8'h09);
        chk("R4 write all", cfg_mask, 4'h9);

        // R10 step collides with a count write on channel 1
        wr(4'hB, 8'h45);
        wr(4'hC, 8'h00);
        cyc(1'b1, 1'b0, 4'h3, 8'h20, 1'b1, 2'd1, 8'h00, "");
        chk("R10 cnt1 written byte", cnt_of(1), 16'h0020);
        chk("R10 addr1 held", addr_of(1), 16'h6655);
        step(2'd1);
        chk("R6 addr1 after free step", addr_of(1), 16'h6656);
        chk("R6 cnt1 after free step", cnt_of(1), 16'h001F);

        // R9 status read in the same cycle as a terminal count
        wr(4'hC, 8'h00);
        rd(4'h8, 8'h04, "R9 status with tc2");
        chk("R9 tc clear", cfg_tc, 4'h0);
        step(2'd2);
        cyc(1'b0, 1'b1, 4'h8, 8'h00, 1'b1, 2'd2, 8'h00, "R9 status during tc");
        chk("R9 tc survives read", cfg_tc, 4'h4);

        // R11 command, temporary read, master clear
        wr(4'h8, 8'h08);
        chk("R11 cmd", cfg_cmd, 8'h08);
        rd(4'hD, 8'h00, "R11 temporary read");
        wr(4'h9, 8'h05);
        chk("R9 sreq ch1", cfg_sreq, 4'h2);
        rd(4'h0, 8'h38, "R3 addr0 low before clear");
        wr(4'hD, 8'hA5);
        chk("R1 mclr cmd", cfg_cmd, 8'h00);
        chk("R1 mclr mask", cfg_mask, 4'hF);
        chk("R1 mclr tc", cfg_tc, 4'h0);
        chk("R1 mclr sreq", cfg_sreq, 4'h0);
        rd(4'h0, 8'h38, "R1 pointer low after mclr");
        chk("R11 addr0 kept", addr_of(0), 16'h1238);
        chk("R11 mode0 kept", mode_of(0), 6'h12);

        repeat (3) @(negedge clk);
        n_cmp++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule